// File: doc/BRIEF.md
# CCD frame-store readout sequencer

This block sequences the readout of a three-phase CCD run in frame-store mode. A start request opens an exposure of programmable length. When the exposure ends, the block clocks the whole imaging half of the parallel array into the storage half. It then reads the storage half out one row at a time. For each row it first shifts the storage section down by one line, then clocks every pixel of the serial register towards one chosen output amplifier. It drives digital enables for the three clock phases of the image section, the storage section and the serial register, and it pulses an ADC convert strobe.

Every strobe is tagged with a column index, a row index and a region code. The region code marks guard, dark-reference, image or overclock pixels. A separate flag shows whether the pixel falls inside a fixed window used by on-board event processing. The serial clocking can run in one of two orders. In the normal order each pixel is converted after it has been clocked. In the digitize-before-clock order the previous pixel is converted before the next one is shifted, so the first strobe of each row is flagged invalid.

A start request that arrives while a frame is in progress is remembered and served as soon as the readout finishes. Clock levels, the ADC itself and event detection sit outside this block.

Top module: `ccd_readout_seq`

## Requirements
- R1: After reset and whenever no transfer or readout is running, all three phase vectors rest at 3'b011 (bit0 = phase 1 and bit1 = phase 2 at the collecting level, bit2 = phase 3 at the barrier level), amp_en_o is 2'b00 and busy_o is low.
- R2: A start request sampled in idle opens an exposure lasting max(integ_i, 1) cycles. During the exposure busy_o stays low and the phases rest. The frame transfer begins in the following cycle.
- R3: The frame transfer moves ROWS rows. For each row, img_phase_o and store_phase_o both step one-hot through 3'b001, 3'b010 and 3'b100, holding each step for par_dwell_i+1 cycles. busy_o rises with the first transfer cycle.
- R4: Each readout row starts with one storage-section line shift, stepped as in R3 while img_phase_o rests. It is followed by NPIX = IMG_COLS + 2*(GUARD_PIX+DARK_PIX) + OVER_PIX serial pixels. Each pixel takes three one-hot serial steps of ser_dwell_i+1 cycles: 001,010,100 towards the left amplifier, and 100,010,001 towards the right amplifier.
- R5: During serial clocking amp_en_o is 2'b01 for the left amplifier (amp_right_i=0) and 2'b10 for the right amplifier. Both bits are never high together.
- R6: In the normal order (dbc_mode_i=0), adc_conv_o pulses in the last cycle of each pixel's third step, with col_o equal to the pixel position p and valid_o high.
- R7: In the digitize-before-clock order, adc_conv_o pulses in the first cycle of each pixel p and reports pixel p-1. The strobe at p=0 has valid_o low with col_o, region_o and in_win_o at zero, and the last pixel is never reported.
- R8: region_o is 0 for guard, 1 for dark reference, 2 for image and 3 for overclock. A row is laid out as guard, dark, image, dark, guard, followed by overclock positions.
- R9: in_win_o is high on a valid strobe exactly when WIN_FIRST <= col_o <= WIN_LAST.
- R10: row_o carries the readout row on every strobe. row_start_o marks the first strobe of every row, and frame_start_o marks the first strobe of row 0.
- R11: A start request taken while a frame is in progress is kept. The next exposure begins in the cycle after the last readout cycle, and busy_o falls in that same cycle.
- R12: When adc_conv_o is low, col_o, row_o, region_o, in_win_o, valid_o and both start pulses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Exposure start request |
| integ_i | input | TIME_W | Exposure length in cycles (0 gives one cycle) |
| par_dwell_i | input | 8 | Parallel step dwell minus one |
| ser_dwell_i | input | 8 | Serial step dwell minus one |
| amp_right_i | input | 1 | Output amplifier select: 0 left, 1 right |
| dbc_mode_i | input | 1 | Digitize-before-clock order |
| img_phase_o | output | 3 | Image section phase enables |
| store_phase_o | output | 3 | Storage section phase enables |
| ser_phase_o | output | 3 | Serial register phase enables |
| amp_en_o | output | 2 | Output amplifier enables |
| adc_conv_o | output | 1 | ADC convert strobe |
| valid_o | output | 1 | Strobe carries a real pixel |
| col_o | output | COL_W | Pixel position of the sample |
| row_o | output | ROW_W | Readout row of the sample |
| region_o | output | 2 | Region code of the sample |
| in_win_o | output | 1 | Sample lies in the event window |
| frame_start_o | output | 1 | First strobe of a frame |
| row_start_o | output | 1 | First strobe of a row |
| busy_o | output | 1 | Transfer or readout in progress |

## Verification
The assertions assume that start_i may arrive at any time, and that integ_i, the dwell inputs, amp_right_i and dbc_mode_i hold steady from each start until the frame they govern ends. The block latches its settings at the start of the exposure, and the bench changes them only while the block is idle. The bench uses a small geometry so that whole frames run in both clocking orders and towards both amplifiers. One start pulse is placed in the middle of a readout to exercise the held request.

// File: rtl/ccdro_pkg.sv
package ccdro_pkg;

    localparam int DWELL_W = 8;

    // Rest level: phases 1 and 2 collecting, phase 3 barrier
    localparam logic [2:0] PHASE_REST = 3'b011;

    typedef enum logic [1:0] {
        REG_GUARD = 2'd0,
        REG_DARK  = 2'd1,
        REG_IMAGE = 2'd2,
        REG_OVER  = 2'd3
    } region_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXPOSE,
        ST_XFER,
        ST_VSHIFT,
        ST_HREAD
    } seq_state_e;

    typedef struct packed {
        logic [DWELL_W-1:0] par_dwell;
        logic [DWELL_W-1:0] ser_dwell;
        logic               amp_right;
        logic               dbc;
    } frame_cfg_t;

    function automatic logic [2:0] step_onehot(input logic [1:0] step, input logic rev);
        logic [2:0] v;
        v = 3'b001 << step;
        if (rev) v = {v[0], v[1], v[2]};
        return v;
    endfunction

endpackage

// File: rtl/ccdro_phase_gen.sv
module ccdro_phase_gen
    import ccdro_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [DW-1:0] dwell,
    input  logic          rev,
    output logic [2:0]    phase,
    output logic          first,
    output logic          last
);
    logic [DW-1:0] cnt;
    logic [1:0]    step;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt  <= '0;
            step <= '0;
        end else if (cnt == dwell) begin
            cnt  <= '0;
            step <= (step == 2'd2) ? 2'd0 : step + 2'd1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign phase = step_onehot(step, rev);
    assign first = en && (cnt == '0) && (step == 2'd0);
    assign last  = en && (cnt == dwell) && (step == 2'd2);

endmodule

// File: rtl/ccdro_expo_timer.sv
module ccdro_expo_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] integ,
    output logic          done
);
    logic [TW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= (integ == '0) ? '0 : integ - 1'b1;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign done = (remain == '0);

endmodule

// File: rtl/ccdro_pixel_tagger.sv
module ccdro_pixel_tagger
    import ccdro_pkg::*;
#(
    parameter int COL_W     = 10,
    parameter int GUARD_PIX = 8,
    parameter int DARK_PIX  = 8,
    parameter int IMG_COLS  = 768,
    parameter int WIN_FIRST = 18,
    parameter int WIN_LAST  = 783
) (
    input  logic [COL_W-1:0] pos,
    output region_e          region,
    output logic             in_win
);
    localparam int LEAD   = GUARD_PIX + DARK_PIX;
    localparam int NPHYS  = IMG_COLS + 2 * LEAD;
    localparam logic [COL_W-1:0] B_GUARD = COL_W'(GUARD_PIX);
    localparam logic [COL_W-1:0] B_DARK  = COL_W'(LEAD);
    localparam logic [COL_W-1:0] B_IMAGE = COL_W'(LEAD + IMG_COLS);
    localparam logic [COL_W-1:0] B_DARK2 = COL_W'(LEAD + IMG_COLS + DARK_PIX);
    localparam logic [COL_W-1:0] B_PHYS  = COL_W'(NPHYS);
    localparam logic [COL_W-1:0] W_LO    = COL_W'(WIN_FIRST);
    localparam logic [COL_W-1:0] W_HI    = COL_W'(WIN_LAST);

    always_comb begin
        if (pos < B_GUARD)      region = REG_GUARD;
        else if (pos < B_DARK)  region = REG_DARK;
        else if (pos < B_IMAGE) region = REG_IMAGE;
        else if (pos < B_DARK2) region = REG_DARK;
        else if (pos < B_PHYS)  region = REG_GUARD;
        else                    region = REG_OVER;
    end

    assign in_win = (pos >= W_LO) && (pos <= W_HI);

endmodule

// File: rtl/ccd_readout_seq.sv
module ccd_readout_seq
    import ccdro_pkg::*;
#(
    parameter int ROWS      = 512,
    parameter int IMG_COLS  = 768,
    parameter int GUARD_PIX = 8,
    parameter int DARK_PIX  = 8,
    parameter int OVER_PIX  = 32,
    parameter int WIN_FIRST = 18,
    parameter int WIN_LAST  = 783,
    parameter int COL_W     = 10,
    parameter int ROW_W     = 10,
    parameter int TIME_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [TIME_W-1:0] integ_i,
    input  logic [DWELL_W-1:0] par_dwell_i,
    input  logic [DWELL_W-1:0] ser_dwell_i,
    input  logic              amp_right_i,
    input  logic              dbc_mode_i,
    output logic [2:0]        img_phase_o,
    output logic [2:0]        store_phase_o,
    output logic [2:0]        ser_phase_o,
    output logic [1:0]        amp_en_o,
    output logic              adc_conv_o,
    output logic              valid_o,
    output logic [COL_W-1:0]  col_o,
    output logic [ROW_W-1:0]  row_o,
    output logic [1:0]        region_o,
    output logic              in_win_o,
    output logic              frame_start_o,
    output logic              row_start_o,
    output logic              busy_o
);
    localparam int NPIX = IMG_COLS + 2 * (GUARD_PIX + DARK_PIX) + OVER_PIX;
    localparam logic [COL_W-1:0] LAST_PIX = COL_W'(NPIX - 1);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

    seq_state_e       state;
    frame_cfg_t       cfg;
    logic             pending;
    logic [ROW_W-1:0] row_cnt;
    logic [COL_W-1:0] pix_cnt;

    logic       par_en, ser_en;
    logic [2:0] par_ph, ser_ph;
    logic       par_first, par_last, ser_first, ser_last;
    logic       expo_done, expo_load;
    logic       row_end, frame_end, go_idle;
    logic       conv, sample_ok;
    logic [COL_W-1:0] sample_pos;
    region_e    tag_region;
    logic       tag_win;

    assign par_en = (state == ST_XFER) || (state == ST_VSHIFT);
    assign ser_en = (state == ST_HREAD);

    ccdro_phase_gen #(.DW(DWELL_W)) u_par (
        .clk(clk), .rst(rst), .en(par_en), .dwell(cfg.par_dwell), .rev(1'b0),
        .phase(par_ph), .first(par_first), .last(par_last)
    );

    ccdro_phase_gen #(.DW(DWELL_W)) u_ser (
        .clk(clk), .rst(rst), .en(ser_en), .dwell(cfg.ser_dwell), .rev(cfg.amp_right),
        .phase(ser_ph), .first(ser_first), .last(ser_last)
    );

    assign row_end   = ser_en && ser_last && (pix_cnt == LAST_PIX);
    assign frame_end = row_end && (row_cnt == LAST_ROW);
    assign go_idle   = (state == ST_IDLE) && (start_i || pending);
    assign expo_load = go_idle || (frame_end && pending);

    ccdro_expo_timer #(.TW(TIME_W)) u_expo (
        .clk(clk), .rst(rst), .load(expo_load), .integ(integ_i), .done(expo_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cfg     <= '0;
            pending <= 1'b0;
            row_cnt <= '0;
            pix_cnt <= '0;
        end else begin
            if (start_i && state != ST_IDLE) pending <= 1'b1;
            case (state)
                ST_IDLE: begin
                    if (go_idle) begin
                        state   <= ST_EXPOSE;
                        pending <= 1'b0;
                        cfg     <= '{par_dwell_i, ser_dwell_i, amp_right_i, dbc_mode_i};
                    end
                end
                ST_EXPOSE: begin
                    if (expo_done) begin
                        state   <= ST_XFER;
                        row_cnt <= '0;
                    end
                end
                ST_XFER: begin
                    if (par_last) begin
                        if (row_cnt == LAST_ROW) begin
                            row_cnt <= '0;
                            state   <= ST_VSHIFT;
                        end else begin
                            row_cnt <= row_cnt + 1'b1;
                        end
                    end
                end
                ST_VSHIFT: begin
                    if (par_last) begin
                        state   <= ST_HREAD;
                        pix_cnt <= '0;
                    end
                end
                ST_HREAD: begin
                    if (ser_last) begin
                        if (pix_cnt == LAST_PIX) begin
                            pix_cnt <= '0;
                            if (row_cnt == LAST_ROW) begin
                                row_cnt <= '0;
                                if (pending) begin
                                    state   <= ST_EXPOSE;
                                    pending <= 1'b0;
                                    cfg     <= '{par_dwell_i, ser_dwell_i, amp_right_i, dbc_mode_i};
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                row_cnt <= row_cnt + 1'b1;
                                state   <= ST_VSHIFT;
                            end
                        end else begin
                            pix_cnt <= pix_cnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Sample tagging
    assign conv       = ser_en && (cfg.dbc ? ser_first : ser_last);
    assign sample_ok  = conv && !(cfg.dbc && pix_cnt == '0);
    assign sample_pos = cfg.dbc ? pix_cnt - 1'b1 : pix_cnt;

    ccdro_pixel_tagger #(
        .COL_W(COL_W), .GUARD_PIX(GUARD_PIX), .DARK_PIX(DARK_PIX),
        .IMG_COLS(IMG_COLS), .WIN_FIRST(WIN_FIRST), .WIN_LAST(WIN_LAST)
    ) u_tag (
        .pos(sample_pos), .region(tag_region), .in_win(tag_win)
    );

    assign img_phase_o   = (state == ST_XFER) ? par_ph : PHASE_REST;
    assign store_phase_o = par_en ? par_ph : PHASE_REST;
    assign ser_phase_o   = ser_en ? ser_ph : PHASE_REST;
    assign amp_en_o      = ser_en ? (cfg.amp_right ? 2'b10 : 2'b01) : 2'b00;
    assign adc_conv_o    = conv;
    assign valid_o       = sample_ok;
    assign col_o         = sample_ok ? sample_pos : '0;
    assign region_o      = sample_ok ? tag_region : REG_GUARD;
    assign in_win_o      = sample_ok && tag_win;
    assign row_o         = conv ? row_cnt : '0;
    assign row_start_o   = conv && (pix_cnt == '0);
    assign frame_start_o = conv && (pix_cnt == '0) && (row_cnt == '0);
    assign busy_o        = par_en || ser_en;

    logic unused_first;
    assign unused_first = par_first;

endmodule

// File: rtl/ccdro_checker.sv
module ccdro_checker #(
    parameter int COL_W     = 10,
    parameter int ROW_W     = 10,
    parameter int WIN_FIRST = 18,
    parameter int WIN_LAST  = 783
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       img_phase_o,
    input logic [2:0]       store_phase_o,
    input logic [2:0]       ser_phase_o,
    input logic [1:0]       amp_en_o,
    input logic             adc_conv_o,
    input logic             valid_o,
    input logic [COL_W-1:0] col_o,
    input logic [ROW_W-1:0] row_o,
    input logic [1:0]       region_o,
    input logic             in_win_o,
    input logic             frame_start_o,
    input logic             row_start_o,
    input logic             busy_o
);
    localparam logic [COL_W-1:0] W_LO = COL_W'(WIN_FIRST);
    localparam logic [COL_W-1:0] W_HI = COL_W'(WIN_LAST);

    assert_rest_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (img_phase_o == 3'b011 && store_phase_o == 3'b011 &&
                     ser_phase_o == 3'b011 && amp_en_o == 2'b00));

    assert_xfer_start_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> (img_phase_o == 3'b001 && store_phase_o == 3'b001));

    assert_xfer_lockstep_R3: assert property (@(posedge clk) disable iff (rst)
        (img_phase_o != 3'b011) |-> ($countones(img_phase_o) == 1 && img_phase_o == store_phase_o));

    assert_amp_excl_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(amp_en_o));

    assert_amp_serial_R5: assert property (@(posedge clk) disable iff (rst)
        (amp_en_o != 2'b00) |-> ($countones(ser_phase_o) == 1 && store_phase_o == 3'b011));

    assert_valid_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> adc_conv_o);

    assert_invalid_first_R7: assert property (@(posedge clk) disable iff (rst)
        (adc_conv_o && !valid_o) |-> (row_start_o && col_o == '0 && !in_win_o));

    assert_window_R9: assert property (@(posedge clk) disable iff (rst)
        in_win_o |-> (valid_o && col_o >= W_LO && col_o <= W_HI));

    assert_frame_row_R10: assert property (@(posedge clk) disable iff (rst)
        frame_start_o |-> (row_start_o && row_o == '0));

    assert_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        !adc_conv_o |-> (col_o == '0 && row_o == '0 && region_o == 2'd0 && !in_win_o &&
                         !valid_o && !row_start_o && !frame_start_o));

endmodule

bind ccd_readout_seq ccdro_checker #(
    .COL_W(COL_W), .ROW_W(ROW_W), .WIN_FIRST(WIN_FIRST), .WIN_LAST(WIN_LAST)
) i_ccdro_checker (
    .clk(clk), .rst(rst),
    .img_phase_o(img_phase_o), .store_phase_o(store_phase_o), .ser_phase_o(ser_phase_o),
    .amp_en_o(amp_en_o), .adc_conv_o(adc_conv_o), .valid_o(valid_o),
    .col_o(col_o), .row_o(row_o), .region_o(region_o), .in_win_o(in_win_o),
    .frame_start_o(frame_start_o), .row_start_o(row_start_o), .busy_o(busy_o)
);

// File: tb/test_ccd_readout_seq.sv
`timescale 1ns/1ps
module test_ccd_readout_seq;
    localparam int T_ROWS = 3;
    localparam int T_IMG  = 12;
    localparam int T_G    = 2;
    localparam int T_D    = 2;
    localparam int T_OV   = 4;
    localparam int T_WLO  = 3;
    localparam int T_WHI  = 16;
    localparam int T_PHYS = T_IMG + 2 * (T_G + T_D);
    localparam int T_NPIX = T_PHYS + T_OV;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic [15:0] integ_i = '0;
    logic [7:0] par_dwell_i = '0;
    logic [7:0] ser_dwell_i = '0;
    logic amp_right_i = 1'b0;
    logic dbc_mode_i = 1'b0;
    logic [2:0] img_phase_o, store_phase_o, ser_phase_o;
    logic [1:0] amp_en_o, region_o;
    logic adc_conv_o, valid_o, in_win_o, frame_start_o, row_start_o, busy_o;
    logic [9:0] col_o, row_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    ccd_readout_seq #(
        .ROWS(T_ROWS), .IMG_COLS(T_IMG), .GUARD_PIX(T_G), .DARK_PIX(T_D),
        .OVER_PIX(T_OV), .WIN_FIRST(T_WLO), .WIN_LAST(T_WHI)
    ) i_ccd_readout_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .integ_i(integ_i),
        .par_dwell_i(par_dwell_i), .ser_dwell_i(ser_dwell_i),
        .amp_right_i(amp_right_i), .dbc_mode_i(dbc_mode_i),
        .img_phase_o(img_phase_o), .store_phase_o(store_phase_o), .ser_phase_o(ser_phase_o),
        .amp_en_o(amp_en_o), .adc_conv_o(adc_conv_o), .valid_o(valid_o),
        .col_o(col_o), .row_o(row_o), .region_o(region_o), .in_win_o(in_win_o),
        .frame_start_o(frame_start_o), .row_start_o(row_start_o), .busy_o(busy_o)
    );

    function automatic int region_of(int p);
        if (p >= T_PHYS) return 3;
        if (p < T_G || p >= T_PHYS - T_G) return 0;
        if (p < T_G + T_D || p >= T_PHYS - T_G - T_D) return 1;
        return 2;
    endfunction

    // Compare every output in the current cycle, then move to the next falling edge
    task automatic chk(input string req, input logic [2:0] ei, input logic [2:0] es,
                       input logic [2:0] esr, input logic [1:0] ea, input logic ec,
                       input logic ev, input int ecol, input int erow, input int ereg,
                       input logic ew, input logic efs, input logic ers, input logic eb);
        logic [38:0] act, exp_v;
        act = {img_phase_o, store_phase_o, ser_phase_o, amp_en_o, adc_conv_o, valid_o,
               col_o, row_o, region_o, in_win_o, frame_start_o, row_start_o, busy_o};
        exp_v = {ei, es, esr, ea, ec, ev, 10'(ecol), 10'(erow), 2'(ereg), ew, efs, ers, eb};
        n_checks++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp_v);
        end
        @(negedge clk);
    endtask

    task automatic chk_rest(input string req);
        chk(req, 3'b011, 3'b011, 3'b011, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    // Behavioural model of one frame, starting in its first exposure cycle
    task automatic run_frame(input int integ, input int pd, input int sd, input bit amp,
                             input bit dbc, input int pend_row, input bit from_pending);
        int e_len;
        e_len = (integ == 0) ? 1 : integ;
        for (int e = 0; e < e_len; e++)
            chk_rest(from_pending ? "R11 R2 exposure after held start" : "R2 exposure");
        for (int r = 0; r < T_ROWS; r++)
            for (int k = 0; k < 3; k++)
                for (int d = 0; d <= pd; d++)
                    chk("R3 frame transfer", 3'(1 << k), 3'(1 << k), 3'b011, 2'b00,
                        0, 0, 0, 0, 0, 0, 0, 0, 1);
        for (int r = 0; r < T_ROWS; r++) begin
            for (int k = 0; k < 3; k++)
                for (int d = 0; d <= pd; d++)
                    chk("R4 store line shift", 3'b011, 3'(1 << k), 3'b011, 2'b00,
                        0, 0, 0, 0, 0, 0, 0, 0, 1);
            for (int p = 0; p < T_NPIX; p++)
                for (int k = 0; k < 3; k++)
                    for (int d = 0; d <= sd; d++) begin
                        logic [2:0] sph;
                        logic [1:0] aen;
                        bit cv, vl;
                        int sp;
                        sph = amp ? 3'(4 >> k) : 3'(1 << k);
                        aen = amp ? 2'b10 : 2'b01;
                        if (dbc) begin
                            cv = (k == 0 && d == 0);
                            sp = p - 1;
                            vl = cv && (p != 0);
                        end else begin
                            cv = (k == 2 && d == sd);
                            sp = p;
                            vl = cv;
                        end
                        if (pend_row == r && p == 0 && k == 0 && d == 0) start_i = 1'b1;
                        if (cv)
                            chk(dbc ? "R7 R8 R9 R10 strobe" : "R6 R8 R9 R10 strobe",
                                3'b011, 3'b011, sph, aen, 1, vl,
                                vl ? sp : 0, r, vl ? region_of(sp) : 0,
                                vl && sp >= T_WLO && sp <= T_WHI,
                                p == 0 && r == 0, p == 0, 1);
                        else
                            chk("R4 R5 R12 serial clocking", 3'b011, 3'b011, sph, aen,
                                0, 0, 0, 0, 0, 0, 0, 0, 1);
                        start_i = 1'b0;
                    end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_rest("R1 in reset");
        rst = 1'b0;
        chk_rest("R1 after reset");
        chk_rest("R1 idle");

        // Normal order, left amplifier
        integ_i = 16'd3; par_dwell_i = 8'd1; ser_dwell_i = 8'd0;
        amp_right_i = 1'b0; dbc_mode_i = 1'b0;
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        run_frame(3, 1, 0, 1'b0, 1'b0, -1, 1'b0);
        chk_rest("R11 R1 idle after frame");
        chk_rest("R1 idle");

        // Digitize-before-clock, right amplifier, zero exposure, held start
        integ_i = 16'd0; par_dwell_i = 8'd0; ser_dwell_i = 8'd1;
        amp_right_i = 1'b1; dbc_mode_i = 1'b1;
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        run_frame(0, 0, 1, 1'b1, 1'b1, 1, 1'b0);
        run_frame(0, 0, 1, 1'b1, 1'b1, -1, 1'b1);
        chk_rest("R11 R1 idle after held frame");

        // Normal order, right amplifier, longer dwell
        integ_i = 16'd5; par_dwell_i = 8'd2; ser_dwell_i = 8'd0;
        amp_right_i = 1'b1; dbc_mode_i = 1'b0;
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        run_frame(5, 2, 0, 1'b1, 1'b0, -1, 1'b0);
        chk_rest("R1 final idle");

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule